// File: doc/BRIEF.md
# Threshold Alert and Status Flag Controller

This block is the alert and status logic of a power-monitoring peripheral. It keeps a 16-bit control word that picks a limit function, the alert polarity and the latching behaviour. It also keeps a 16-bit limit value and three status flags: alert-function hit, conversion ready and math overflow. Each time a conversion finishes, the block takes the fresh shunt-voltage, bus-voltage and power words. It compares the one limit function with the highest priority against the limit and updates the flags. It then drives an open-collector alert pin, modelled here as a pull-down enable.

Software reaches the two registers through a single-cycle read/write strobe port, with read data registered. A read of the control word returns the flags as they were before the read and clears them on the same edge. The conversion engine supplies a done pulse together with the result words, an overflow pulse, and a configuration-write indication with a power-down qualifier. The alert may also be asserted when conversion data are ready. This source is ORed with the chosen limit function.

Top module: `lim_alert_ctrl`

## Requirements
- R1: After reset, both registers read as 0x0000 and `alert_pd` is 0 (the pin is released, because an active-low alert is idle high).
- R2: Register address 0 is the control word and address 1 is the limit. In the control word, bits 15..10 and 1..0 are writable. Writes to bits 9..2 are ignored. Read data appear on `reg_rdata` one clock after the read strobe.
- R3: Bits 15 (shunt above), 14 (shunt below), 13 (bus above), 12 (bus below) and 11 (power above) enable limit functions. When several are set, only the highest-numbered one is evaluated.
- R4: All compares are strict. Shunt is compared as two's complement. Bus and power are compared unsigned.
- R5: The conversion-ready flag (control bit 3) is set by `conv_done`. It is cleared by a control-word read and by `cfg_wr` with `cfg_pwrdn` low. A configuration write with `cfg_pwrdn` high leaves it set.
- R6: When bit 10 is set, the alert is also active whenever the conversion-ready flag is set.
- R7: In latch mode (bit 0 = 1), the alert-function flag (bit 4) and the alert stay active after a hit until the control word is read. That read still returns the flag set.
- R8: In transparent mode (bit 0 = 0), the alert-function flag takes the hit result of every conversion, so it clears on the next conversion that does not hit.
- R9: With polarity bit 1 = 0, `alert_pd` equals the alert state. With bit 1 = 1, `alert_pd` equals its inverse.
- R10: The math overflow flag (bit 2) is set by a `math_ovf` pulse and cleared by a control-word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 selects the control word, 1 selects the limit |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| conv_done | input | 1 | One-cycle pulse marking the end of a conversion |
| shunt_res | input | 16 | Shunt-voltage result, two's complement |
| bus_res | input | 16 | Bus-voltage result, unsigned |
| power_res | input | 16 | Power result, unsigned |
| math_ovf | input | 1 | Arithmetic overflow pulse |
| cfg_wr | input | 1 | Configuration register was written |
| cfg_pwrdn | input | 1 | The configuration write selected power-down |
| alert_pd | output | 1 | Pull-down enable of the open-collector alert pin |

## Verification
Every result is due exactly one rising edge after the strobe that causes it:
- read data after `reg_rd`;
- flags and `alert_pd` after `conv_done`, `cfg_wr`, `math_ovf`, a control-word write or a clearing read.

The driver records each expected value with the cycle index of that edge. The monitor compares it at the following falling edge, so no sample races the edge that produced it. Sequences are ordered so that each clearing event, such as a read, a configuration write or a non-hitting conversion, is followed by an alert or read-back check before any further stimulus.

// File: rtl/lim_alert_pkg.sv
package lim_alert_pkg;
  // number of priority-ordered limit functions in the top bits of the control word
  localparam int unsigned NFUNC    = 5;
  // function index inside the enable slice (highest index = highest priority)
  localparam int unsigned FN_SH_HI = 4;
  localparam int unsigned FN_SH_LO = 3;
  localparam int unsigned FN_BU_HI = 2;
  localparam int unsigned FN_BU_LO = 1;
  localparam int unsigned FN_PW_HI = 0;
  // control word bit positions
  localparam int unsigned B_RDY_EN = 10;
  localparam int unsigned B_HIT    = 4;
  localparam int unsigned B_RDY    = 3;
  localparam int unsigned B_OVF    = 2;
  localparam int unsigned B_POL    = 1;
  localparam int unsigned B_LATCH  = 0;
endpackage

// File: rtl/lim_func_eval.sv
module lim_func_eval
  import lim_alert_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [NFUNC-1:0] fn_en,
  input  logic [DW-1:0]    shunt_v,
  input  logic [DW-1:0]    bus_v,
  input  logic [DW-1:0]    pwr_v,
  input  logic [DW-1:0]    lim_v,
  output logic             fn_hit
);
  logic [NFUNC-1:0] cmp;
  logic [NFUNC-1:0] pick;

  always_comb begin
    cmp           = '0;
    cmp[FN_SH_HI] = $signed(shunt_v) > $signed(lim_v);
    cmp[FN_SH_LO] = $signed(shunt_v) < $signed(lim_v);
    cmp[FN_BU_HI] = bus_v > lim_v;
    cmp[FN_BU_LO] = bus_v < lim_v;
    cmp[FN_PW_HI] = pwr_v > lim_v;
  end

  // highest enabled function wins
  always_comb begin
    logic higher;
    higher = 1'b0;
    pick   = '0;
    for (int i = int'(NFUNC) - 1; i >= 0; i--) begin
      pick[i] = fn_en[i] & ~higher;
      higher  = higher | fn_en[i];
    end
  end

  assign fn_hit = |(pick & cmp);
endmodule

// File: rtl/lim_flag_unit.sv
module lim_flag_unit (
  input  logic clk,
  input  logic rst,
  input  logic conv_done,
  input  logic fn_hit,
  input  logic latch_en,
  input  logic ctl_rd,
  input  logic cfg_clr,
  input  logic ovf_in,
  output logic hit_d,
  output logic rdy_d,
  output logic hit_q,
  output logic rdy_q,
  output logic ovf_q
);
  logic ovf_d;

  always_comb begin
    if (latch_en) begin
      if (conv_done && fn_hit) hit_d = 1'b1;
      else if (ctl_rd)         hit_d = 1'b0;
      else                     hit_d = hit_q;
    end else begin
      hit_d = conv_done ? fn_hit : hit_q;
    end
    if (conv_done)              rdy_d = 1'b1;
    else if (ctl_rd || cfg_clr) rdy_d = 1'b0;
    else                        rdy_d = rdy_q;
    if (ovf_in)      ovf_d = 1'b1;
    else if (ctl_rd) ovf_d = 1'b0;
    else             ovf_d = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      rdy_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
      rdy_q <= rdy_d;
      ovf_q <= ovf_d;
    end
  end

  AST_RDY_SET: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> rdy_q);                                          // R5
  AST_RDY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ((ctl_rd || cfg_clr) && !conv_done) |=> !rdy_q);                // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (latch_en && hit_q && !ctl_rd) |=> hit_q);                      // R7
  AST_TRANSP_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !latch_en) |=> (hit_q == $past(fn_hit)));         // R8
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    ovf_in |=> ovf_q);                                              // R10
endmodule

// File: rtl/lim_alert_drive.sv
module lim_alert_drive (
  input  logic clk,
  input  logic rst,
  input  logic active_d,
  input  logic pol_d,
  output logic alert_pd
);
  always_ff @(posedge clk) begin
    if (rst) alert_pd <= 1'b0;
    else     alert_pd <= active_d ^ pol_d;
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !active_d |=> (alert_pd == $past(pol_d)));                      // R9
endmodule

// File: rtl/lim_alert_ctrl.sv
module lim_alert_ctrl
  import lim_alert_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic          reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          conv_done,
  input  logic [DW-1:0] shunt_res,
  input  logic [DW-1:0] bus_res,
  input  logic [DW-1:0] power_res,
  input  logic          math_ovf,
  input  logic          cfg_wr,
  input  logic          cfg_pwrdn,
  output logic          alert_pd
);
  localparam logic [DW-1:0] FN_FIELD = {{NFUNC{1'b1}}, {(DW-NFUNC){1'b0}}};
  localparam logic [DW-1:0] WR_MASK  = FN_FIELD
                                     | (DW'(1) << B_RDY_EN)
                                     | (DW'(1) << B_POL)
                                     | (DW'(1) << B_LATCH);

  logic [DW-1:0]    ctl_q, ctl_d, lim_q, ctl_view;
  logic             ctl_rd, cfg_clr, fn_hit;
  logic             hit_d, rdy_d, hit_q, rdy_q, ovf_q;
  logic             active_d;
  logic [NFUNC-1:0] fn_en;

  assign ctl_rd  = reg_rd && (reg_addr == 1'b0);
  assign cfg_clr = cfg_wr && !cfg_pwrdn;
  assign ctl_d   = (reg_wr && reg_addr == 1'b0) ? (reg_wdata & WR_MASK) : ctl_q;
  assign fn_en   = ctl_q[DW-1 -: NFUNC];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      lim_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      if (reg_wr && reg_addr == 1'b1) lim_q <= reg_wdata;
    end
  end

  lim_func_eval #(.DW(DW)) u_eval (
    .fn_en  (fn_en),
    .shunt_v(shunt_res),
    .bus_v  (bus_res),
    .pwr_v  (power_res),
    .lim_v  (lim_q),
    .fn_hit (fn_hit)
  );

  lim_flag_unit u_flags (
    .clk      (clk),
    .rst      (rst),
    .conv_done(conv_done),
    .fn_hit   (fn_hit),
    .latch_en (ctl_q[B_LATCH]),
    .ctl_rd   (ctl_rd),
    .cfg_clr  (cfg_clr),
    .ovf_in   (math_ovf),
    .hit_d    (hit_d),
    .rdy_d    (rdy_d),
    .hit_q    (hit_q),
    .rdy_q    (rdy_q),
    .ovf_q    (ovf_q)
  );

  // control word as seen by software: stored fields plus live flags
  always_comb begin
    ctl_view          = ctl_q;
    ctl_view[B_HIT]   = hit_q;
    ctl_view[B_RDY]   = rdy_q;
    ctl_view[B_OVF]   = ovf_q;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= reg_addr ? lim_q : ctl_view;
  end

  assign active_d = hit_d || (ctl_d[B_RDY_EN] && rdy_d);

  lim_alert_drive u_drive (
    .clk     (clk),
    .rst     (rst),
    .active_d(active_d),
    .pol_d   (ctl_d[B_POL]),
    .alert_pd(alert_pd)
  );

  AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (rst)
    alert_pd == ((hit_q || (ctl_q[B_RDY_EN] && rdy_q)) ^ ctl_q[B_POL])); // R6
  AST_RD_PRECLEAR: assert property (@(posedge clk) disable iff (rst)
    ctl_rd |=> (reg_rdata[B_HIT] == $past(hit_q)));                    // R7
  AST_FLAG_BITS_RO: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_addr) |=> (ctl_q[9:5] == 5'd0));                   // R2
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (reg_rdata == '0 && !alert_pd));                    // R1
endmodule

// File: tb/lim_alert_ctrl_bench.sv
`timescale 1ns/1ps
module lim_alert_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        conv_done = 0, math_ovf = 0, cfg_wr = 0, cfg_pwrdn = 0;
  logic [15:0] shunt_res = '0, bus_res = '0, power_res = '0;
  logic        alert_pd;

  always #2.5 clk = ~clk;

  lim_alert_ctrl u_lim_alert_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_done(conv_done),
    .shunt_res(shunt_res), .bus_res(bus_res), .power_res(power_res),
    .math_ovf(math_ovf), .cfg_wr(cfg_wr), .cfg_pwrdn(cfg_pwrdn), .alert_pd(alert_pd)
  );

  typedef struct {
    int          due;
    bit          is_rd;
    logic [15:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb[$];
  sb_item_t cur;
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares each item at the falling edge after its due rising edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      cur = sb.pop_front();
      n_chk++;
      if (cur.is_rd) begin
        if (reg_rdata !== cur.exp) begin
          n_bad++;
          $display("FAIL %s: rdata actual %h expected %h", cur.tag, reg_rdata, cur.exp);
        end
      end else if (alert_pd !== cur.exp[0]) begin
        n_bad++;
        $display("FAIL %s: alert_pd actual %b expected %b", cur.tag, alert_pd, cur.exp[0]);
      end
    end
  end

  task automatic push(input bit r, input logic [15:0] e, input string t);
    sb_item_t it;
    it.due = cyc + 1; it.is_rd = r; it.exp = e; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic a, input logic [15:0] e, input string t);
    @(negedge clk); reg_rd = 1; reg_addr = a; push(1'b1, e, t);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic conv(input logic [15:0] sh, input logic [15:0] bu, input logic [15:0] pw);
    @(negedge clk); conv_done = 1; shunt_res = sh; bus_res = bu; power_res = pw;
    @(negedge clk); conv_done = 0;
  endtask

  task automatic cfg(input logic pd);
    @(negedge clk); cfg_wr = 1; cfg_pwrdn = pd;
    @(negedge clk); cfg_wr = 0; cfg_pwrdn = 0;
  endtask

  task automatic ovf_pulse();
    @(negedge clk); math_ovf = 1;
    @(negedge clk); math_ovf = 0;
  endtask

  task automatic chk_alert(input logic e, input string t);
    @(negedge clk); push(1'b0, {15'd0, e}, t);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk_alert(1'b0, "R1 alert idle");
    rd(1'b0, 16'h0000, "R1 ctl reset");
    rd(1'b1, 16'h0000, "R1 limit reset");
    // R2 writable fields; R9 polarity with no alert
    wr(1'b0, 16'hFFFF);
    rd(1'b0, 16'hFC03, "R2 ctl write mask");
    chk_alert(1'b1, "R9 inverted idle");
    wr(1'b0, 16'h0000);
    chk_alert(1'b0, "R9 normal idle");
    wr(1'b1, 16'h0100);
    rd(1'b1, 16'h0100, "R2 limit readback");
    // R4 compares, R8 transparent
    wr(1'b0, 16'h8000);
    conv(16'h0101, 0, 0); chk_alert(1'b1, "R4 shunt above");
    conv(16'h0100, 0, 0); chk_alert(1'b0, "R4 shunt equal strict / R8 clear");
    conv(16'h8000, 0, 0); chk_alert(1'b0, "R4 shunt signed negative");
    wr(1'b0, 16'h4000);
    conv(16'hFFFF, 0, 0); chk_alert(1'b1, "R4 shunt below signed");
    wr(1'b0, 16'h2000);
    conv(0, 16'h8000, 0); chk_alert(1'b1, "R4 bus above unsigned");
    conv(0, 16'h0050, 0); chk_alert(1'b0, "R8 bus no hit clears");
    wr(1'b0, 16'h1000);
    conv(0, 16'h00FF, 0); chk_alert(1'b1, "R4 bus below");
    wr(1'b0, 16'h0800);
    conv(0, 0, 16'h0101); chk_alert(1'b1, "R4 power above");
    conv(0, 0, 16'h0100); chk_alert(1'b0, "R4 power equal strict");
    // R3 priority
    wr(1'b0, 16'h8800);
    conv(16'h0000, 0, 16'hFFFF); chk_alert(1'b0, "R3 power masked by shunt");
    conv(16'h0200, 0, 16'h0000); chk_alert(1'b1, "R3 shunt chosen");
    wr(1'b0, 16'h1800);
    conv(0, 16'h0200, 16'hFFFF); chk_alert(1'b0, "R3 power masked by bus");
    // R7 latch
    wr(1'b0, 16'h8001);
    conv(16'h0200, 0, 0); chk_alert(1'b1, "R7 latch set");
    conv(16'h0000, 0, 0); chk_alert(1'b1, "R7 latch hold");
    rd(1'b0, 16'h8019, "R7 read pre-clear flags");
    chk_alert(1'b0, "R7 read clears alert");
    rd(1'b0, 16'h8001, "R7 flags cleared");
    // R5 ready flag
    wr(1'b0, 16'h0000);
    conv(0, 0, 0);
    rd(1'b0, 16'h0008, "R5 ready set");
    rd(1'b0, 16'h0000, "R5 read clears ready");
    conv(0, 0, 0); cfg(1'b1);
    rd(1'b0, 16'h0008, "R5 power-down write keeps ready");
    conv(0, 0, 0); cfg(1'b0);
    rd(1'b0, 16'h0000, "R5 config write clears ready");
    // R6 ready drives alert
    wr(1'b0, 16'h0400);
    conv(0, 0, 0); chk_alert(1'b1, "R6 ready alert");
    cfg(1'b0); chk_alert(1'b0, "R6 config clear drops alert");
    conv(0, 0, 0);
    rd(1'b0, 16'h0408, "R6 ready visible");
    chk_alert(1'b0, "R6 read drops alert");
    // R10 overflow
    ovf_pulse();
    rd(1'b0, 16'h0404, "R10 overflow set");
    rd(1'b0, 16'h0400, "R10 overflow cleared");
    // R9 polarity with alert
    wr(1'b0, 16'h8002);
    chk_alert(1'b1, "R9 inverted idle level");
    conv(16'h0200, 0, 0); chk_alert(1'b0, "R9 inverted active");
    conv(16'h0000, 0, 0); chk_alert(1'b1, "R9 inverted release");
    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule